// File: doc/BRIEF.md
# Chainable Serial Front End for a 12-bit Converter

This block is the digital input side of a 12-bit voltage-output converter. A host sends a 16-bit word on a serial data line. The word is framed by an active-low frame strobe and is clocked on the falling edges of a serial clock. The word collects in a 16-bit input register. Its lower 12 bits are then copied into a code latch, which drives the converter. The copy happens in one of two ways:

- on a falling edge of an active-low load strobe, or
- automatically at the 16th serial clock fall of a frame, when the load strobe is held low.

A clear input forces a code that depends on the data format. A format select picks straight binary or two's complement. In two's complement, the latch stores the offset-binary form by inverting the code's most significant bit.

When chaining is enabled, the top bit of the input register leaves on a serial output. Several converters can then be cascaded on one data line and loaded together.

All serial-side pins are brought into a fast system clock through two-flop synchronisers and detected by edge. The system clock must run at least eight times faster than the serial clock.

Top module: `sdac_chain_if`

## Requirements
- R1: After reset the code latch reads 12'h000 and the serial output is low.
- R2: While the frame strobe is low, each serial clock fall shifts the data bit into the input register, most significant bit first. A load-strobe fall copies bits [11:0] of the register into the latch; bits [15:12] do not reach the latch.
- R3: With the load strobe high and no clear, the latch keeps its value through a whole frame.
- R4: With the load strobe held low, the latch takes the new word at the 16th serial clock fall of a frame. A frame with only 15 falls leaves the latch unchanged.
- R5: A falling edge of the frame strobe restarts the bit count. After an aborted frame, the automatic load happens on the 16th fall of the new frame.
- R6: With the format select at 1 (two's complement), the latch holds the loaded code with bit 11 inverted. With the format select at 0, the code is stored unchanged.
- R7: While clear is low, the latch holds 12'h000 in binary format and 12'h800 in two's complement. Clear wins over a load-strobe fall. Clear does not alter the input register.
- R8: With chain enable high, the serial output shows bit 15 of the input register. A word therefore reappears on the output 16 serial clocks later.
- R9: With chain enable low, the serial output stays low.
- R10: Serial clock falls while the frame strobe is high do not change the input register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| frame_n_i | input | 1 | Active-low frame strobe |
| sdata_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Active-low load strobe; held low selects automatic load |
| clr_n_i | input | 1 | Active-low level clear |
| fmt_twos_i | input | 1 | Format select: 1 = two's complement, 0 = binary |
| chain_en_i | input | 1 | Enables the chained serial output |
| sdata_o | output | 1 | Chained serial data out |
| code_o | output | 12 | Unsigned code to the converter |

## Verification
The hardest state to reach from the ports is the content of the input register while clear holds the latch. It is also hard to see what register bits beyond the latch width do. The bench loads a word, holds clear while pulsing the load strobe, then releases clear and loads again to show the untouched word. It observes the chained output one bit before each serial fall of a second word, which exposes the full 16-bit register.

// File: rtl/sdac_chain_if.sv
module sdac_chain_if #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              frame_n_i,
  input  logic              sdata_i,
  input  logic              load_n_i,
  input  logic              clr_n_i,
  input  logic              fmt_twos_i,
  input  logic              chain_en_i,
  output logic              sdata_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [4:0] IDLE = 5'b11110;

  logic [4:0] s1, s2, s3;
  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE; s2 <= IDLE; s3 <= IDLE;
    end else begin
      s1 <= {sclk_i, frame_n_i, load_n_i, clr_n_i, sdata_i};
      s2 <= s1;
      s3 <= s2;
    end

  logic sclk_fall, frame_fall, framed, load_fall, load_low, clr_low, shift, auto_ld;
  logic [CODE_W-1:0] mask;
  logic [WORD_W-1:0] sreg_nx;

  assign sclk_fall  = s3[4] & ~s2[4];
  assign frame_fall = s3[3] & ~s2[3];
  assign framed     = ~s2[3];
  assign load_fall  = s3[2] & ~s2[2];
  assign load_low   = ~s2[2];
  assign clr_low    = ~s2[1];
  assign shift      = sclk_fall & framed;
  assign sreg_nx    = {sreg[WORD_W-2:0], s2[0]};
  assign auto_ld    = shift & load_low & (cnt == LAST);
  assign mask       = {fmt_twos_i, {(CODE_W-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sreg <= '0;
    else if (shift) sreg <= sreg_nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (frame_fall) cnt <= '0;
    else if (shift && cnt != FULL) cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) code_o <= '0;
    else if (clr_low) code_o <= mask;
    else if (auto_ld) code_o <= sreg_nx[CODE_W-1:0] ^ mask;
    else if (load_fall) code_o <= sreg[CODE_W-1:0] ^ mask;

  assign sdata_o = chain_en_i & sreg[WORD_W-1];
endmodule

// File: rtl/sdac_chain_if_chk.sv
module sdac_chain_if_chk #(
  parameter int WORD_W = 16,
  parameter int CODE_W = 12,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chain_en_i,
  input logic              fmt_twos_i,
  input logic              sdata_o,
  input logic [CODE_W-1:0] code_o,
  input logic [WORD_W-1:0] sreg,
  input logic [CNT_W-1:0]  cnt,
  input logic              sclk_fall,
  input logic              framed,
  input logic              frame_fall,
  input logic              load_fall,
  input logic              clr_low
);
  p_chain_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_en_i |-> !sdata_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_fall && !clr_low && !sclk_fall) |=> $stable(code_o));
  p_clear_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_low && $past(clr_low) && $stable(fmt_twos_i)) |=> $stable(code_o));
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_fall |=> cnt == '0);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && framed) |=> sreg[WORD_W-1:1] == $past(sreg[WORD_W-2:0]));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |=> $stable(sreg));
endmodule

bind sdac_chain_if sdac_chain_if_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) chk (
  .clk(clk), .rst_n(rst_n), .chain_en_i(chain_en_i), .fmt_twos_i(fmt_twos_i),
  .sdata_o(sdata_o), .code_o(code_o), .sreg(sreg), .cnt(cnt),
  .sclk_fall(sclk_fall), .framed(framed), .frame_fall(frame_fall),
  .load_fall(load_fall), .clr_low(clr_low)
);

// File: tb/sdac_chain_if_test.sv
module sdac_chain_if_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, frame_n = 1'b1, sdin = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic fmt = 1'b0, chain = 1'b0;
  logic sdout;
  logic [11:0] code;
  int checks = 0, fails = 0;
  localparam int HALF = 8;

  always #4 clk = ~clk;

  sdac_chain_if uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .frame_n_i(frame_n), .sdata_i(sdin),
    .load_n_i(load_n), .clr_n_i(clr_n), .fmt_twos_i(fmt), .chain_en_i(chain),
    .sdata_o(sdout), .code_o(code)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [15:0] w, input int n, input bit chk, input logic [15:0] prev);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; sdin = w[15-i];
      wait_clk(HALF);
      if (chk) check("R8 chained bit", {15'b0, sdout}, {15'b0, prev[15-i]});
      sclk = 1'b0;
      wait_clk(HALF);
    end
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic frame(input logic [15:0] w, input int n);
    frame_n = 1'b0; wait_clk(HALF);
    shift_bits(w, n, 1'b0, 16'h0);
    frame_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic pulse_load;
    load_n = 1'b0; wait_clk(HALF);
    load_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic t_reset;
    check("R1 reset code", {4'h0, code}, 16'h0);
    check("R1 reset sdo", {15'b0, sdout}, 16'h0);
  endtask

  task automatic t_strobed;
    frame(16'hA5C3, 16);
    check("R3 hold before load", {4'h0, code}, 16'h0);
    pulse_load();
    check("R2 strobed load, top nibble dropped", {4'h0, code}, 16'h05C3);
  endtask

  task automatic t_twos;
    fmt = 1'b1;
    frame(16'h0123, 16);
    pulse_load();
    check("R6 twos msb inverted", {4'h0, code}, 16'h0923);
    frame(16'hF9AB, 16);
    pulse_load();
    check("R6 twos msb set", {4'h0, code}, 16'h01AB);
    fmt = 1'b0;
  endtask

  task automatic t_auto;
    load_n = 1'b0; wait_clk(HALF);
    frame(16'h1234, 16);
    check("R4 auto load", {4'h0, code}, 16'h0234);
    frame(16'h0F0F, 15);
    check("R4 15 falls no load", {4'h0, code}, 16'h0234);
    frame(16'h5555, 7);
    frame(16'hF7FE, 16);
    check("R5 restart then auto load", {4'h0, code}, 16'h07FE);
    load_n = 1'b1; wait_clk(HALF);
  endtask

  task automatic t_clear;
    frame(16'h0ABC, 16);
    clr_n = 1'b0; wait_clk(HALF);
    check("R7 clear binary", {4'h0, code}, 16'h0);
    pulse_load();
    check("R7 clear beats load", {4'h0, code}, 16'h0);
    fmt = 1'b1; wait_clk(4);
    check("R7 clear twos", {4'h0, code}, 16'h0800);
    fmt = 1'b0;
    clr_n = 1'b1; wait_clk(HALF);
    check("R7 level release keeps", {4'h0, code}, 16'h0);
    pulse_load();
    check("R7 register kept", {4'h0, code}, 16'h0ABC);
  endtask

  task automatic t_idle_sclk;
    shift_bits(16'hFFFF, 16, 1'b0, 16'h0);
    pulse_load();
    check("R10 idle clocks ignored", {4'h0, code}, 16'h0ABC);
  endtask

  task automatic t_chain;
    chain = 1'b1;
    frame_n = 1'b0; wait_clk(HALF);
    shift_bits(16'hC3A6, 16, 1'b0, 16'h0);
    shift_bits(16'h5F01, 16, 1'b1, 16'hC3A6);
    frame_n = 1'b1; wait_clk(HALF);
    check("R8 after second word", {15'b0, sdout}, 16'h0);
    chain = 1'b0; wait_clk(2);
    frame(16'hFFFF, 16);
    check("R9 chain off", {15'b0, sdout}, 16'h0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_strobed();
    t_twos();
    t_auto();
    t_clear();
    t_idle_sclk();
    t_chain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule